// File: doc/BRIEF.md
# Descriptor Cache Flush Controller with Address Blocking

This block carries out flush commands for a small descriptor cache. Each command names a 40-bit descriptor address, which arrives as a 32-bit low part and an 8-bit high part, and one of four blocking resources. The command can free its resource before running, and it can ask for a forwarding step before the line is written out. It writes the line out and either invalidates it or keeps it valid. After the flush it can park the address in the chosen resource, so that later cache accesses to that address are refused. A whole-cache command ignores all of these options. It flushes every line and then holds the entire cache blocked until a cache-unblock request clears it.

The forwarding engine and the cache write-back path sit outside the block and are reached through request/done handshakes. A separate unblock port frees a single resource or lifts the whole-cache block. A lookup port tells the cache, in the same cycle, whether an address may be used. Every flush or unblock request produces exactly one single-cycle status pulse with a 2-bit code.

Top module: `flush_blk_ctrl`

## Requirements
- R1: After synchronous reset, no resource is occupied, the cache is not blocked, `cmd_ready` is high, and `sts_valid`, `fwd_req` and `wb_req` are low.
- R2: Every accepted flush or unblock request yields exactly one `sts_valid` pulse. The codes are 0 for success, 1 for a release of a free resource, 2 for a block on a busy resource, and 3 for an unblock of something not held.
- R3: With `cmd_release` set, the selected resource is freed before the flush runs. If that resource is already free, the command returns code 1, issues no forwarding and no write-back, and leaves every resource as it was.
- R4: With `cmd_block` set, a successful flush stores the command address in the selected resource when the write-back completes. From then on, `lk_blocked` is high for that exact address.
- R5: A block request on a resource that is occupied and not released in the same command returns code 2. It issues no forwarding and no write-back, and the resource keeps its old address.
- R6: A single-line flush raises `wb_req` with `wb_all`=0 and `wb_addr` equal to the command address. `wb_inval` is 0 when `cmd_keep` is set and 1 otherwise.
- R7: With `cmd_fwd` set, `fwd_req` is raised with the command address and completes before `wb_req` rises. With `cmd_fwd` clear, no forwarding takes place.
- R8: With `cmd_whole` set, the release, block, keep and forward options and the index are ignored. The write-back runs with `wb_all`=1 and `wb_inval`=1, and the resources are unchanged. On completion, every lookup reports blocked.
- R9: An unblock request with `unb_whole`=1 clears the whole-cache block and returns code 0. If the cache is not blocked, it returns code 3.
- R10: An unblock request with `unb_whole`=0 frees resource `unb_idx` and returns code 0. If that resource is already free, it returns code 3.
- R11: `lk_blocked` follows `lk_addr` in the same cycle. It is high when the address matches an occupied resource or when the whole cache is blocked.
- R12: When a flush command and an unblock request are both pending in idle, the flush command is taken first: `cmd_ready`=1 and `unb_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Flush command present |
| cmd_ready | output | 1 | Flush command accepted this cycle if valid |
| cmd_addr_lo | input | 32 | Low part of the descriptor address |
| cmd_addr_hi | input | 8 | High part of the descriptor address |
| cmd_idx | input | 2 | Blocking resource selector |
| cmd_release | input | 1 | Free the selected resource first |
| cmd_block | input | 1 | Park the address in the resource after the flush |
| cmd_keep | input | 1 | Write the line out without invalidating it |
| cmd_fwd | input | 1 | Run the forwarding step before the flush |
| cmd_whole | input | 1 | Flush the whole cache and hold it blocked |
| unb_valid | input | 1 | Unblock request present |
| unb_ready | output | 1 | Unblock request accepted this cycle if valid |
| unb_whole | input | 1 | 1: lift the cache block, 0: free one resource |
| unb_idx | input | 2 | Resource to free |
| fwd_req | output | 1 | Forwarding request, held until done |
| fwd_done | input | 1 | Forwarding finished |
| wb_req | output | 1 | Write-back request, held until done |
| wb_all | output | 1 | Write-back covers every line |
| wb_inval | output | 1 | Invalidate the line(s) after writing |
| wb_addr | output | 40 | Line address for forwarding and write-back |
| wb_done | input | 1 | Write-back finished |
| lk_addr | input | 40 | Cache lookup address |
| lk_blocked | output | 1 | Lookup must be refused |
| sts_valid | output | 1 | Status pulse |
| sts_code | output | 2 | Status code |

## Verification
A resource whose occupied bit or stored address goes wrong shows up at once on `lk_blocked` for that address. It also shows up at the next command or unblock that names the resource, which then returns a different status code. For this reason the bench follows each command with lookups on every address it expects to be parked. A stuck whole-cache block flag shows up on the first lookup after the write-back completes or after the unblock. A latched option that is lost shows up during the same command, as a missing or misordered `fwd_req` or a wrong `wb_inval`/`wb_addr`.

// File: rtl/flush_blk_pkg.sv
package flush_blk_pkg;
  typedef enum logic [1:0] {
    STS_OK       = 2'd0,
    STS_REL_FREE = 2'd1,
    STS_BLK_BUSY = 2'd2,
    STS_UNB_FREE = 2'd3
  } sts_code_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FWD   = 2'd1,
    S_FLUSH = 2'd2
  } seq_state_e;
endpackage

// File: rtl/flush_res_table.sv
module flush_res_table #(
  parameter int ADDR_W  = 40,
  parameter int NUM_RES = 4,
  localparam int IDX_W  = $clog2(NUM_RES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rel_en,
  input  logic [IDX_W-1:0]  rel_idx,
  input  logic              set_en,
  input  logic [IDX_W-1:0]  set_idx,
  input  logic [ADDR_W-1:0] set_addr,
  output logic [NUM_RES-1:0] occ,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit
);
  logic [ADDR_W-1:0]  tag_q [NUM_RES];
  logic [NUM_RES-1:0] occ_q;
  logic [NUM_RES-1:0] hit_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q <= '0;
    end else begin
      if (rel_en) occ_q[rel_idx] <= 1'b0;
      if (set_en) occ_q[set_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (set_en) tag_q[set_idx] <= set_addr;
  end

  for (genvar g = 0; g < NUM_RES; g++) begin : g_cmp
    assign hit_vec[g] = occ_q[g] && (tag_q[g] == lk_addr);
  end

  assign occ    = occ_q;
  assign lk_hit = |hit_vec;
endmodule

// File: rtl/flush_seq.sv
module flush_seq
  import flush_blk_pkg::*;
#(
  parameter int ADDR_W  = 40,
  parameter int NUM_RES = 4,
  localparam int IDX_W  = $clog2(NUM_RES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [IDX_W-1:0]   cmd_idx,
  input  logic               cmd_release,
  input  logic               cmd_block,
  input  logic               cmd_keep,
  input  logic               cmd_fwd,
  input  logic               cmd_whole,
  input  logic               unb_valid,
  output logic               unb_ready,
  input  logic               unb_whole,
  input  logic [IDX_W-1:0]   unb_idx,
  output logic               fwd_req,
  input  logic               fwd_done,
  output logic               wb_req,
  output logic               wb_all,
  output logic               wb_inval,
  output logic [ADDR_W-1:0]  op_addr,
  input  logic               wb_done,
  input  logic [NUM_RES-1:0] occ,
  output logic               rel_en,
  output logic [IDX_W-1:0]   rel_idx,
  output logic               set_en,
  output logic [IDX_W-1:0]   set_idx,
  output logic [ADDR_W-1:0]  set_addr,
  output logic               cache_blk,
  output logic               sts_valid,
  output logic [1:0]         sts_code
);
  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  idx_q;
  logic              block_q, keep_q, whole_q, cblk_q;
  logic              sv_q;
  sts_code_e         sc_q;

  logic idle, cmd_fire, unb_fire, occ_sel, rel_err, blk_err;

  assign idle      = (state_q == S_IDLE);
  assign cmd_ready = idle;
  assign unb_ready = idle && !cmd_valid;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign unb_fire  = unb_valid && unb_ready;

  assign occ_sel = occ[cmd_idx];
  assign rel_err = !cmd_whole && cmd_release && !occ_sel;
  assign blk_err = !cmd_whole && cmd_block && occ_sel && !cmd_release;

  always_comb begin
    rel_en  = 1'b0;
    rel_idx = cmd_idx;
    if (cmd_fire) begin
      rel_en = !cmd_whole && cmd_release && occ_sel;
    end else if (unb_fire) begin
      rel_en  = !unb_whole && occ[unb_idx];
      rel_idx = unb_idx;
    end
  end

  assign set_en   = (state_q == S_FLUSH) && wb_done && block_q && !whole_q;
  assign set_idx  = idx_q;
  assign set_addr = addr_q;

  assign fwd_req   = (state_q == S_FWD);
  assign wb_req    = (state_q == S_FLUSH);
  assign wb_all    = whole_q;
  assign wb_inval  = whole_q || !keep_q;
  assign op_addr   = addr_q;
  assign cache_blk = cblk_q;
  assign sts_valid = sv_q;
  assign sts_code  = sc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      idx_q   <= '0;
      block_q <= 1'b0;
      keep_q  <= 1'b0;
      whole_q <= 1'b0;
      cblk_q  <= 1'b0;
      sv_q    <= 1'b0;
      sc_q    <= STS_OK;
    end else begin
      sv_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (cmd_fire) begin
            addr_q  <= cmd_whole ? '0 : cmd_addr;
            idx_q   <= cmd_idx;
            block_q <= cmd_block && !cmd_whole;
            keep_q  <= cmd_keep && !cmd_whole;
            whole_q <= cmd_whole;
            if (cmd_whole) begin
              state_q <= S_FLUSH;
            end else if (rel_err) begin
              sv_q <= 1'b1;
              sc_q <= STS_REL_FREE;
            end else if (blk_err) begin
              sv_q <= 1'b1;
              sc_q <= STS_BLK_BUSY;
            end else begin
              state_q <= cmd_fwd ? S_FWD : S_FLUSH;
            end
          end else if (unb_fire) begin
            sv_q <= 1'b1;
            if (unb_whole) begin
              sc_q   <= cblk_q ? STS_OK : STS_UNB_FREE;
              cblk_q <= 1'b0;
            end else begin
              sc_q <= occ[unb_idx] ? STS_OK : STS_UNB_FREE;
            end
          end
        end
        S_FWD: begin
          if (fwd_done) state_q <= S_FLUSH;
        end
        S_FLUSH: begin
          if (wb_done) begin
            state_q <= S_IDLE;
            sv_q    <= 1'b1;
            sc_q    <= STS_OK;
            if (whole_q) cblk_q <= 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flush_blk_ctrl.sv
module flush_blk_ctrl #(
  parameter int ADDR_W  = 40,
  parameter int LO_W    = 32,
  parameter int NUM_RES = 4,
  localparam int HI_W   = ADDR_W - LO_W,
  localparam int IDX_W  = $clog2(NUM_RES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [LO_W-1:0]   cmd_addr_lo,
  input  logic [HI_W-1:0]   cmd_addr_hi,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic              cmd_release,
  input  logic              cmd_block,
  input  logic              cmd_keep,
  input  logic              cmd_fwd,
  input  logic              cmd_whole,
  input  logic              unb_valid,
  output logic              unb_ready,
  input  logic              unb_whole,
  input  logic [IDX_W-1:0]  unb_idx,
  output logic              fwd_req,
  input  logic              fwd_done,
  output logic              wb_req,
  output logic              wb_all,
  output logic              wb_inval,
  output logic [ADDR_W-1:0] wb_addr,
  input  logic              wb_done,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_blocked,
  output logic              sts_valid,
  output logic [1:0]        sts_code
);
  logic [NUM_RES-1:0] occ;
  logic               rel_en, set_en, lk_hit, cache_blk;
  logic [IDX_W-1:0]   rel_idx, set_idx;
  logic [ADDR_W-1:0]  set_addr;

  flush_seq #(.ADDR_W(ADDR_W), .NUM_RES(NUM_RES)) u_seq (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr({cmd_addr_hi, cmd_addr_lo}), .cmd_idx(cmd_idx),
    .cmd_release(cmd_release), .cmd_block(cmd_block), .cmd_keep(cmd_keep),
    .cmd_fwd(cmd_fwd), .cmd_whole(cmd_whole),
    .unb_valid(unb_valid), .unb_ready(unb_ready),
    .unb_whole(unb_whole), .unb_idx(unb_idx),
    .fwd_req(fwd_req), .fwd_done(fwd_done),
    .wb_req(wb_req), .wb_all(wb_all), .wb_inval(wb_inval),
    .op_addr(wb_addr), .wb_done(wb_done),
    .occ(occ), .rel_en(rel_en), .rel_idx(rel_idx),
    .set_en(set_en), .set_idx(set_idx), .set_addr(set_addr),
    .cache_blk(cache_blk), .sts_valid(sts_valid), .sts_code(sts_code)
  );

  flush_res_table #(.ADDR_W(ADDR_W), .NUM_RES(NUM_RES)) u_tab (
    .clk(clk), .rst(rst),
    .rel_en(rel_en), .rel_idx(rel_idx),
    .set_en(set_en), .set_idx(set_idx), .set_addr(set_addr),
    .occ(occ), .lk_addr(lk_addr), .lk_hit(lk_hit)
  );

  assign lk_blocked = cache_blk || lk_hit;
endmodule

// File: rtl/flush_blk_ctrl_chk.sv
module flush_blk_ctrl_chk #(
  parameter int ADDR_W = 40
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_ready,
  input logic              unb_ready,
  input logic              fwd_req,
  input logic              wb_req,
  input logic              wb_all,
  input logic              wb_inval,
  input logic [ADDR_W-1:0] wb_addr,
  input logic              wb_done,
  input logic              lk_blocked,
  input logic              sts_valid
);
  // R1: the cycle after reset carries no status
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> !sts_valid && !wb_req && !fwd_req);

  // R7: forwarding and write-back never overlap
  a_r7_fwd_before_wb: assert property (@(posedge clk) disable iff (rst)
    fwd_req |-> !wb_req);

  // R8: whole-cache write-back always invalidates
  a_r8_whole_inval: assert property (@(posedge clk) disable iff (rst)
    (wb_req && wb_all) |-> wb_inval);

  // R8: completed whole flush blocks every lookup
  a_r8_whole_blocks: assert property (@(posedge clk) disable iff (rst)
    (wb_req && wb_all && wb_done) |=> lk_blocked);

  // R2: completed write-back yields a status pulse
  a_r2_status_after_wb: assert property (@(posedge clk) disable iff (rst)
    (wb_req && wb_done) |=> sts_valid);

  // R6: pending write-back holds its address
  a_r6_wb_held: assert property (@(posedge clk) disable iff (rst)
    (wb_req && !wb_done) |=> wb_req && $stable(wb_addr));

  // R12: no request taken while a flush is in flight
  a_r12_busy_no_accept: assert property (@(posedge clk) disable iff (rst)
    (wb_req || fwd_req) |-> !cmd_ready && !unb_ready);
endmodule

bind flush_blk_ctrl flush_blk_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .unb_ready(unb_ready),
  .fwd_req(fwd_req), .wb_req(wb_req), .wb_all(wb_all), .wb_inval(wb_inval),
  .wb_addr(wb_addr), .wb_done(wb_done), .lk_blocked(lk_blocked),
  .sts_valid(sts_valid)
);

// File: tb/flush_blk_ctrl_bench.sv
module flush_blk_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        cmd_valid = 0, cmd_release = 0, cmd_block = 0, cmd_keep = 0;
  logic        cmd_fwd = 0, cmd_whole = 0;
  logic [31:0] cmd_addr_lo = 0;
  logic [7:0]  cmd_addr_hi = 0;
  logic [1:0]  cmd_idx = 0, unb_idx = 0;
  logic        unb_valid = 0, unb_whole = 0, fwd_done = 0, wb_done = 0;
  logic [39:0] lk_addr = 0;
  logic        cmd_ready, unb_ready, fwd_req, wb_req, wb_all, wb_inval;
  logic        lk_blocked, sts_valid;
  logic [39:0] wb_addr;
  logic [1:0]  sts_code;

  flush_blk_ctrl u_flush_blk_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr_lo(cmd_addr_lo), .cmd_addr_hi(cmd_addr_hi), .cmd_idx(cmd_idx),
    .cmd_release(cmd_release), .cmd_block(cmd_block), .cmd_keep(cmd_keep),
    .cmd_fwd(cmd_fwd), .cmd_whole(cmd_whole), .unb_valid(unb_valid),
    .unb_ready(unb_ready), .unb_whole(unb_whole), .unb_idx(unb_idx),
    .fwd_req(fwd_req), .fwd_done(fwd_done), .wb_req(wb_req), .wb_all(wb_all),
    .wb_inval(wb_inval), .wb_addr(wb_addr), .wb_done(wb_done),
    .lk_addr(lk_addr), .lk_blocked(lk_blocked), .sts_valid(sts_valid),
    .sts_code(sts_code)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit occ_m [4];
  logic [39:0] adr_m [4];
  bit cblk_m = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit model_hit(input logic [39:0] a);
    model_hit = cblk_m;
    for (int i = 0; i < 4; i++) if (occ_m[i] && adr_m[i] == a) model_hit = 1;
  endfunction

  task automatic check_lk(input logic [39:0] a, input string req);
    @(negedge clk);
    lk_addr = a;
    #1;
    chk(lk_blocked == model_hit(a), req, lk_blocked, model_hit(a));
  endtask

  // flush command; returns observations
  task automatic run_cmd(input logic [39:0] a, input logic [1:0] idx,
                         input bit rel, input bit blk, input bit keep,
                         input bit fwd, input bit whole,
                         output logic [1:0] code, output bit saw_fwd,
                         output bit saw_wb, output bit order_bad,
                         output bit all_o, output bit inv_o,
                         output logic [39:0] addr_o, output logic [39:0] faddr_o);
    @(negedge clk);
    cmd_valid = 1; {cmd_addr_hi, cmd_addr_lo} = a; cmd_idx = idx;
    cmd_release = rel; cmd_block = blk; cmd_keep = keep; cmd_fwd = fwd; cmd_whole = whole;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    saw_fwd = 0; saw_wb = 0; order_bad = 0; code = 2'bxx;
    all_o = 0; inv_o = 0; addr_o = '0; faddr_o = '0;
    for (int n = 0; n < 40; n++) begin
      if (sts_valid) begin code = sts_code; break; end
      if (fwd_req) begin
        saw_fwd = 1; faddr_o = wb_addr;
        if (saw_wb) order_bad = 1;
        fwd_done = 1;
      end
      if (wb_req) begin
        saw_wb = 1; all_o = wb_all; inv_o = wb_inval; addr_o = wb_addr;
        wb_done = 1;
      end
      @(negedge clk);
      fwd_done = 0; wb_done = 0;
    end
  endtask

  task automatic run_unb(input bit whole, input logic [1:0] idx, output logic [1:0] code);
    @(negedge clk);
    unb_valid = 1; unb_whole = whole; unb_idx = idx;
    #1;
    while (!unb_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    unb_valid = 0;
    code = sts_valid ? sts_code : 2'bxx;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [1:0] code, ecode;
    bit sf, sw, ob, ao, io;
    logic [39:0] ad, fa, a;
    for (int i = 0; i < 4; i++) begin occ_m[i] = 0; adr_m[i] = '0; end
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk); #1;
    // R1 reset state
    chk(cmd_ready == 1, "R1 cmd_ready", cmd_ready, 1);
    chk(sts_valid == 0, "R1 sts_valid", sts_valid, 0);
    chk(!fwd_req && !wb_req, "R1 requests", {fwd_req, wb_req}, 0);
    lk_addr = 40'h12_3456_789A; #1;
    chk(lk_blocked == 0, "R1 lk_blocked", lk_blocked, 0);

    // sweep: every resource x every option combination
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 16; k++) begin
        bit rel = k[0], blk = k[1], keep = k[2], fwd = k[3];
        a = {8'(r * 16 + k), 32'h1000_0000 + 32'(r * 4096 + k * 4)};
        if (rel && !occ_m[r]) ecode = 2'd1;
        else if (blk && occ_m[r] && !rel) ecode = 2'd2;
        else ecode = 2'd0;
        run_cmd(a, 2'(r), rel, blk, keep, fwd, 0, code, sf, sw, ob, ao, io, ad, fa);
        chk(code == ecode, "R2 status code", code, ecode);
        if (ecode == 2'd1) chk(!sw && !sf, "R3 no flush on free release", {sf, sw}, 0);
        else if (ecode == 2'd2) chk(!sw && !sf, "R5 no flush on busy block", {sf, sw}, 0);
        else begin
          chk(sw && !ao, "R6 single-line write-back", {sw, ao}, 2'b10);
          chk(io == !keep, "R6 wb_inval", io, !keep);
          chk(ad == a, "R6 wb_addr", ad, a);
          chk(sf == fwd, "R7 forward step", sf, fwd);
          if (fwd) chk(!ob && fa == a, "R7 forward order/addr", fa, a);
          if (rel) occ_m[r] = 0;   // R3 release applied
          if (blk) begin occ_m[r] = 1; adr_m[r] = a; end
        end
        check_lk(a, "R4 lookup of command address");
        for (int i = 0; i < 4; i++) check_lk(adr_m[i], "R11 lookup of parked address");
      end
    end

    // R8 whole-cache flush with every other option set
    run_cmd(40'hFF_FFFF_FFFF, 2'd1, 1, 1, 1, 1, 1, code, sf, sw, ob, ao, io, ad, fa);
    chk(code == 0, "R8 whole status", code, 0);
    chk(sw && ao && io, "R8 whole write-back all+inval", {sw, ao, io}, 3'b111);
    chk(!sf, "R8 no forward on whole", sf, 0);
    cblk_m = 1;
    for (int j = 0; j < 8; j++) check_lk(40'(j * 40'h13_5791_3579), "R8 all lookups blocked");

    // R9 lift cache block; R8 resources unchanged
    run_unb(1, 2'd0, code);
    chk(code == 0, "R9 unblock cache", code, 0);
    cblk_m = 0;
    for (int i = 0; i < 4; i++) check_lk(adr_m[i], "R8 resources unchanged by whole flush");
    check_lk(40'h00_0000_0004, "R9 free address after unblock");
    run_unb(1, 2'd0, code);
    chk(code == 3, "R9 unblock cache when clear", code, 3);

    // R10 unblock each resource twice
    for (int i = 0; i < 4; i++) begin
      run_unb(0, 2'(i), code);
      ecode = occ_m[i] ? 2'd0 : 2'd3;
      chk(code == ecode, "R10 unblock resource", code, ecode);
      occ_m[i] = 0;
      check_lk(adr_m[i], "R10 lookup after unblock");
      run_unb(0, 2'(i), code);
      chk(code == 3, "R10 unblock free resource", code, 3);
    end

    // R12 priority of flush command over unblock
    @(negedge clk);
    unb_valid = 1; unb_whole = 0; unb_idx = 0;
    cmd_valid = 1;
    #1;
    chk(cmd_ready && !unb_ready, "R12 flush command first", {cmd_ready, unb_ready}, 2'b10);
    unb_valid = 0; cmd_valid = 0;
    run_cmd(40'h5A_0000_0100, 2'd2, 0, 1, 0, 0, 0, code, sf, sw, ob, ao, io, ad, fa);
    chk(code == 0, "R12 command completes", code, 0);
    occ_m[2] = 1; adr_m[2] = 40'h5A_0000_0100;
    check_lk(40'h5A_0000_0100, "R4 parked after priority test");
    check_lk(40'h5A_0000_0101, "R11 neighbour not blocked");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule